// File: doc/BRIEF.md
# Beat-Frequency Pulse Selector

This block sits between a two-clock mixer and the word-line path of a memory characterization array. The mixer combines two clocks whose periods differ slightly. The result is a train of pulses, one per fast-clock cycle, whose widths grow by a fixed step from one pulse to the next. Because of this, the position of a pulse inside one beat cycle sets its width. The selector tracks that position and opens a gate, the pass signal, around the pulse or pulses that the programmed codeword names.

The mixer also delivers a beat marker that is subject to clock jitter, so the marker is not used directly as the position reference. Instead, the block times the interval between markers in fast-clock cycles and averages 128 of these measurements. It then runs its own beat-cycle counter from the averaged length. An internal sync marks position zero of every beat. A status flag reports that the first average is ready, and no pulse is passed before it is.

The codeword and the repeat count are captured only where one beat ends and the next begins. A repeat count opens the gate for several back-to-back pulses, which models repeated reads of one cell. A codeword that does not fit inside the averaged beat is refused, and an error flag is shown for that beat.

Top module: `beat_pulse_sel`

## Requirements
- R1: After reset `avgValid` is low. The first `beatMark` only starts interval timing. Every later marker completes one interval sample, equal to the number of clock cycles since the previous marker. `avgValid` goes high at the clock edge that takes the 128th sample, which is the edge of the 129th marker, and it stays high afterwards.
- R2: The averaged beat length is the floor of the sum of 128 samples divided by 128. The averaging restarts after each group of 128 samples, and the newest average sets the length of each beat that begins after it is formed.
- R3: The first `beatMark` seen while `avgValid` is already high starts the beat counter at position 0. From then on, the position advances by one per clock and returns to 0 at the edge where position+1 is at least the averaged length. `syncOut` is high exactly in the cycles at position 0.
- R4: `passOut` stays low until the beat counter has started, and it is never high while `avgValid` is low.
- R5: With an accepted codeword C and an effective repeat N, `passOut` is high at the positions C through C+N-1 of a beat, cut off at the end of the beat, and low at every other position.
- R6: A repeat count of 0 is treated as N = 1.
- R7: A repeat count above MAX_REP (default 6) is treated as N = MAX_REP. Values from 1 to MAX_REP are used unchanged.
- R8: When the captured codeword is equal to or larger than the averaged length in force at capture, `codeErr` is high for that whole beat and `passOut` stays low. The flag is cleared at the next capture of a codeword that fits.
- R9: `codeIn` and `repeatIn` are captured only at the edge that starts position 0, which is either the start of the counter or a wrap. A change at any other time has no effect until the next such edge.
- R10: `pulseOut` equals `pulseIn` while `passOut` is high and is low otherwise.
- R11: While reset is active, `passOut`, `pulseOut`, `syncOut`, `avgValid` and `codeErr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one train pulse per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Mixed pulse train from the two-clock mixer |
| beatMark | input | 1 | One-cycle marker at each beat boundary of the mixer |
| codeIn | input | PER_W | Beat position of the wanted pulse |
| repeatIn | input | REP_W | Number of back-to-back pulses to pass |
| passOut | output | 1 | Gate that is open for the selected positions |
| pulseOut | output | 1 | Gated pulse train toward the word-line path |
| syncOut | output | 1 | High at position 0 of each internally timed beat |
| avgValid | output | 1 | First averaged beat length available |
| codeErr | output | 1 | Captured codeword does not fit the current beat |

## Verification
The hardest situation to reach is a change of the averaged length while the beat counter is running. A new average that is shorter than the present position must force a wrap at once, and codewords that were legal become errors. The stimulus first sends more than 128 intervals that alternate between 11 and 13 cycles, which averages to 12. It then switches the marker spacing to 9 cycles. As a result, one averaging window straddles the change and the next window is pure, so the beat shrinks twice while pulses are being selected. Throughout the run, codeword and repeat values are swept at a 7-cycle rhythm that is not tied to the beat. This places changes in the middle of beats, and it hits out-of-range codewords as well as zero and oversized repeat counts.

// File: rtl/beat_pulse_pkg.sv
package beat_pulse_pkg;

  // Strobes from the control FSM to the selection datapath
  typedef struct packed {
    logic run;      // beat counter is running
    logic loadCfg;  // capture codeword / repeat at beat boundary
    logic posClr;   // return position to zero
    logic posInc;   // advance position
  } ctrl_strobe_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } sel_state_t;

endpackage

// File: rtl/beat_period_avg.sv
module beat_period_avg #(
  parameter int PER_W     = 8,
  parameter int AVG_SHIFT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beatMark,
  output logic [PER_W-1:0] avgLen,
  output logic             avgValid
);

  localparam int SUM_W = PER_W + AVG_SHIFT;
  localparam logic [PER_W-1:0] GAP_MAX = {{(PER_W-1){1'b1}}, 1'b0};

  logic [PER_W-1:0]     gapCnt;
  logic                 haveMark;
  logic [AVG_SHIFT-1:0] sampleCnt;
  logic [SUM_W-1:0]     sumAcc;
  logic [SUM_W-1:0]     sumNext;
  logic [PER_W-1:0]     sample;
  logic                 lastSample;

  assign sample     = gapCnt + PER_W'(1);
  assign sumNext    = sumAcc + SUM_W'(sample);
  assign lastSample = &sampleCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapCnt    <= '0;
      haveMark  <= 1'b0;
      sampleCnt <= '0;
      sumAcc    <= '0;
      avgLen    <= '0;
      avgValid  <= 1'b0;
    end else if (beatMark) begin
      gapCnt   <= '0;
      haveMark <= 1'b1;
      if (haveMark) begin
        sampleCnt <= sampleCnt + AVG_SHIFT'(1);
        if (lastSample) begin
          sumAcc   <= '0;
          avgLen   <= sumNext[SUM_W-1:AVG_SHIFT];
          avgValid <= 1'b1;
        end else begin
          sumAcc <= sumNext;
        end
      end
    end else if (gapCnt != GAP_MAX) begin
      gapCnt <= gapCnt + PER_W'(1);
    end
  end

  // R1
  avg_valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avgValid |=> avgValid);

endmodule

// File: rtl/beat_sel_ctrl.sv
module beat_sel_ctrl
  import beat_pulse_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beatMark,
  input  logic         avgValid,
  input  logic         posLast,
  output ctrl_strobe_t strobe
);

  sel_state_t st, stNext;

  always_comb begin
    strobe     = '0;
    stNext     = st;
    strobe.run = (st == S_RUN);
    case (st)
      S_IDLE: begin
        if (beatMark && avgValid) begin
          stNext         = S_RUN;
          strobe.posClr  = 1'b1;
          strobe.loadCfg = 1'b1;
        end
      end
      default: begin
        if (posLast) begin
          strobe.posClr  = 1'b1;
          strobe.loadCfg = 1'b1;
        end else begin
          strobe.posInc = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= stNext;
  end

  // R4
  run_needs_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.run |-> avgValid);

endmodule

// File: rtl/beat_sel_datapath.sv
module beat_sel_datapath
  import beat_pulse_pkg::*;
#(
  parameter int PER_W   = 8,
  parameter int REP_W   = 4,
  parameter int MAX_REP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_strobe_t     strobe,
  input  logic [PER_W-1:0] codeIn,
  input  logic [REP_W-1:0] repeatIn,
  input  logic [PER_W-1:0] avgLen,
  output logic             posLast,
  output logic             passSel,
  output logic             syncSel,
  output logic             errFlag
);

  localparam logic [REP_W-1:0] REP_CAP = REP_W'(MAX_REP);

  logic [PER_W-1:0] pos;
  logic [PER_W-1:0] codeL;
  logic [REP_W-1:0] repL;
  logic [REP_W-1:0] repSat;
  logic [PER_W-1:0] offs;
  logic             inWindow;

  always_comb begin
    if (repeatIn == '0)          repSat = REP_W'(1);
    else if (repeatIn > REP_CAP) repSat = REP_CAP;
    else                         repSat = repeatIn;
  end

  assign posLast  = ({1'b0, pos} + (PER_W+1)'(1)) >= {1'b0, avgLen};
  assign offs     = pos - codeL;
  assign inWindow = (pos >= codeL) && (offs < PER_W'(repL));
  assign passSel  = strobe.run && !errFlag && inWindow;
  assign syncSel  = strobe.run && (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      codeL   <= '0;
      repL    <= REP_W'(1);
      errFlag <= 1'b0;
    end else begin
      if (strobe.posClr)      pos <= '0;
      else if (strobe.posInc) pos <= pos + PER_W'(1);
      if (strobe.loadCfg) begin
        codeL   <= codeIn;
        repL    <= repSat;
        errFlag <= (codeIn >= avgLen);
      end
    end
  end

  // R6 R7
  rep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadCfg |=> (repL != '0) && (repL <= REP_CAP));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadCfg |=> $stable(codeL) && $stable(repL));

endmodule

// File: rtl/beat_pulse_sel.sv
module beat_pulse_sel
  import beat_pulse_pkg::*;
#(
  parameter int PER_W     = 8,
  parameter int AVG_SHIFT = 7,
  parameter int REP_W     = 4,
  parameter int MAX_REP   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulseIn,
  input  logic             beatMark,
  input  logic [PER_W-1:0] codeIn,
  input  logic [REP_W-1:0] repeatIn,
  output logic             passOut,
  output logic             pulseOut,
  output logic             syncOut,
  output logic             avgValid,
  output logic             codeErr
);

  logic [PER_W-1:0] avgLen;
  logic             posLast;
  ctrl_strobe_t     strobe;

  beat_period_avg #(.PER_W(PER_W), .AVG_SHIFT(AVG_SHIFT)) i_avg (
    .clk(clk), .rst_n(rst_n), .beatMark(beatMark),
    .avgLen(avgLen), .avgValid(avgValid)
  );

  beat_sel_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .beatMark(beatMark), .avgValid(avgValid),
    .posLast(posLast), .strobe(strobe)
  );

  beat_sel_datapath #(.PER_W(PER_W), .REP_W(REP_W), .MAX_REP(MAX_REP)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .codeIn(codeIn),
    .repeatIn(repeatIn), .avgLen(avgLen), .posLast(posLast),
    .passSel(passOut), .syncSel(syncOut), .errFlag(codeErr)
  );

  assign pulseOut = pulseIn & passOut;

  // R4
  pass_after_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    passOut |-> avgValid);

  // R3
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syncOut && avgLen > PER_W'(1)) |=> !syncOut);

endmodule

// File: tb/test_beat_pulse_sel.sv
`timescale 1ns/1ps
module test_beat_pulse_sel;

  localparam int PER_W = 8;
  localparam int REP_W = 4;
  localparam int MAXR  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulseIn = 1'b0;
  logic beatMark = 1'b0;
  logic [PER_W-1:0] codeIn = '0;
  logic [REP_W-1:0] repeatIn = '0;
  logic passOut, pulseOut, syncOut, avgValid, codeErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  beat_pulse_sel i_beat_pulse_sel (
    .clk(clk), .rst_n(rst_n), .pulseIn(pulseIn), .beatMark(beatMark),
    .codeIn(codeIn), .repeatIn(repeatIn), .passOut(passOut),
    .pulseOut(pulseOut), .syncOut(syncOut), .avgValid(avgValid),
    .codeErr(codeErr)
  );

  // reference model state
  int mGap = 0, mSum = 0, mNum = 0, mAvg = 0;
  bit mHave = 0, mValid = 0, mRun = 0, mErr = 0;
  int mPos = 0, mCode = 0, mRep = 1;
  int passSeen = 0, errSeen = 0, satSeen = 0, syncSeen = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic int effRep(int r);
    if (r == 0) return 1;        // R6
    if (r > MAXR) return MAXR;   // R7
    return r;
  endfunction

  task automatic modelEdge();
    bit oldValid;
    int oldAvg;
    oldValid = mValid;
    oldAvg   = mAvg;
    // R1 R2: interval sampling and averaging
    if (beatMark) begin
      if (mHave) begin
        mSum += mGap + 1;
        mNum++;
        if (mNum == 128) begin
          mAvg = mSum / 128;
          mValid = 1;
          mSum = 0;
          mNum = 0;
        end
      end
      mHave = 1;
      mGap = 0;
    end else begin
      mGap++;
    end
    // R3 R9: beat counter and boundary capture
    if (!mRun) begin
      if (beatMark && oldValid) begin
        mRun = 1; mPos = 0;
        mCode = int'(codeIn); mRep = effRep(int'(repeatIn));
        mErr = (int'(codeIn) >= oldAvg);
      end
    end else if (mPos + 1 >= oldAvg) begin
      mPos = 0;
      mCode = int'(codeIn); mRep = effRep(int'(repeatIn));
      mErr = (int'(codeIn) >= oldAvg);
      if (int'(repeatIn) > MAXR) satSeen++;
    end else begin
      mPos++;
    end
  endtask

  task automatic checkOutputs();
    bit expPass, expSync;
    expSync = mRun && (mPos == 0);
    expPass = mRun && !mErr && (mPos >= mCode) && (mPos - mCode < mRep);
    chk("R1 avgValid", int'(avgValid), int'(mValid));
    chk("R3 syncOut", int'(syncOut), int'(expSync));
    chk("R5 passOut", int'(passOut), int'(expPass));
    chk("R8 codeErr", int'(codeErr), int'(mRun && mErr));
    chk("R10 pulseOut", int'(pulseOut), int'(pulseIn && expPass));
    if (!mValid) chk("R4 no pass before average", int'(passOut), 0);
    if (expPass) passSeen++;
    if (mRun && mErr) errSeen++;
    if (expSync) syncSeen++;
  endtask

  initial begin
    int cyc;
    int markIdx;
    int nextMark;
    int per;
    // R11: reset state
    repeat (3) begin
      @(negedge clk);
      pulseIn = 1'b1;
      beatMark = 1'b1;
      #2;
      chk("R11 passOut", int'(passOut), 0);
      chk("R11 pulseOut", int'(pulseOut), 0);
      chk("R11 syncOut", int'(syncOut), 0);
      chk("R11 avgValid", int'(avgValid), 0);
      chk("R11 codeErr", int'(codeErr), 0);
    end
    cyc = 0;
    markIdx = 0;
    nextMark = 3;
    while (markIdx < 450) begin
      @(negedge clk);
      rst_n = 1'b1;
      beatMark = (cyc == nextMark);
      if (beatMark) begin
        per = (markIdx < 200) ? ((markIdx % 2) ? 13 : 11) : 9;
        nextMark = cyc + per;
        markIdx++;
      end
      pulseIn = (cyc % 3) != 0;
      if (cyc % 7 == 0) begin
        codeIn   = PER_W'(((cyc / 7) * 5) % 16);
        repeatIn = REP_W'(((cyc / 7) * 3) % 16);
      end
      #2;
      checkOutputs();
      @(posedge clk);
      modelEdge();
      cyc++;
    end
    chk("R5 some pulses passed", int'(passSeen > 0), 1);
    chk("R8 oversized codeword met", int'(errSeen > 0), 1);
    chk("R7 oversized repeat met", int'(satSeen > 0), 1);
    chk("R2 beats timed from average", int'(syncSeen > 100), 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule